// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit gathers the event pulses raised by an I2C controller's bus engine and FIFOs into a latched status register. An enable register masks that status, and the result drives one registered interrupt line. Software can acknowledge events in two ways. It can write ones to the status register, and each 1 clears the matching bit. It can also read a compact vector code that names the most urgent pending, enabled event; that read clears the event it names.

Some status bits are latched events. One bit is a live level that mirrors the bus-busy signal from the bus engine, and writes do not affect it. The register port is plain strobe-and-data. Status, enable and vector values are always visible on output pins, so a read carries no handshake. A vector read is a one-cycle strobe that is sampled together with the vector value shown in that same cycle.

Top module: `i2c_event_irq`

## Requirements
- R1: After reset, status (latched bits), enable, vector and the interrupt line are all 0.
- R2: A 1 on an event input bit sets the status bit at the same position at the next clock edge. The latched positions are 0 arbitration lost, 1 no-ack, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 RX draining and 14 TX draining.
- R3: A status write clears every latched bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: If an event pulse and a clear (by a status write or a vector read) hit the same bit in the same cycle, the bit is set after the edge.
- R5: Status bit 12 always equals the bus-busy input. Event pulses and status writes do not change it.
- R6: Only enable bits 0 to 4, 13 and 14 are writable, and all other enable bits read 0. Status bits 5, 6, 7 and 15 always read 0, and event pulses on them are ignored.
- R7: The interrupt output is 1 in the cycle after any bit of (status AND enable) is 1, and 0 in the cycle after none is.
- R8: The vector output is 0 when none of status bits 0 to 4 is both set and enabled. Otherwise it is 1 plus the lowest such bit position: 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready.
- R9: A vector read strobe clears only the status bit named by the vector shown in that cycle. A strobe while the vector is 0 changes nothing.
- R10: A vector read and a status write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse_i | input | 16 | One-cycle event pulses, one per status position |
| bus_busy_i | input | 1 | Live bus-busy level |
| status_wr_i | input | 1 | Status write strobe (write-one-to-clear) |
| status_wdata_i | input | 16 | Status write data |
| enable_wr_i | input | 1 | Enable register write strobe |
| enable_wdata_i | input | 16 | Enable register write data |
| vector_rd_i | input | 1 | Vector read strobe (clears the reported event) |
| status_o | output | 16 | Status readback |
| enable_o | output | 16 | Enable readback |
| vector_o | output | 3 | Encoded highest-priority pending enabled event |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Two functions can meet in one cycle: an event setting a bit, and either acknowledge path clearing it. The bench drives an event pulse in the same cycle as a clearing status write, and in another cycle as a vector read that names the same bit. In both cases it expects the bit to stay set and the vector to name it again. It also drives a vector read and a status write together on different bits and expects both to be gone after the edge.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int REG_W    = 16;
  localparam int VEC_SRC  = 5;
  localparam int CODE_W   = $clog2(VEC_SRC + 1);
  localparam int BUSY_BIT = 12;
  // latched event positions: 0-4, 8-11, 13, 14
  localparam logic [REG_W-1:0] LATCH_MASK = 16'h6F1F;
  // interrupt-capable positions: 0-4, 13, 14
  localparam logic [REG_W-1:0] IRQ_MASK   = 16'h601F;
endpackage

// File: rtl/evt_status_bits.sv
module evt_status_bits #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  input  logic [W-1:0] vec_clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] clr_any;

  assign clr_any = ({W{clr_wr_i}} & clr_data_i) | vec_clr_i;

  // set has priority over either clear
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (set_i | (q & ~clr_any)) & MASK;
  end

  assign q_o = q;

  for (genvar i = 0; i < W; i++) begin : g_bit_chk
    if (MASK[i]) begin : g_latched
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q_o[i]); // R4
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_data_i[i] && !set_i[i]) |=> !q_o[i]); // R3
      AST_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i[i] && !(clr_wr_i && clr_data_i[i]) && !vec_clr_i[i]) |=> $stable(q_o[i])); // R3
    end else begin : g_fixed
      AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> !q_o[i]); // R6
    end
  end
endmodule

// File: rtl/evt_enable_reg.sv
module evt_enable_reg #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (wr_i) q <= data_i & MASK;
  end

  assign q_o = q;

  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o)); // R6
endmodule

// File: rtl/evt_vector_enc.sv
module evt_vector_enc #(
  parameter int N      = 5,
  parameter int CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      pend_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N-1:0]      sel_o
);
  // lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = CODE_W'(i + 1);
        sel_o  = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/i2c_event_irq.sv
module i2c_event_irq
  import i2c_evt_pkg::*;
#(
  parameter int               W        = REG_W,
  parameter int               NSRC     = VEC_SRC,
  parameter int               CW       = CODE_W,
  parameter int               BUSY_POS = BUSY_BIT,
  parameter logic [W-1:0]     LMASK    = LATCH_MASK,
  parameter logic [W-1:0]     EMASK    = IRQ_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_pulse_i,
  input  logic          bus_busy_i,
  input  logic          status_wr_i,
  input  logic [W-1:0]  status_wdata_i,
  input  logic          enable_wr_i,
  input  logic [W-1:0]  enable_wdata_i,
  input  logic          vector_rd_i,
  output logic [W-1:0]  status_o,
  output logic [W-1:0]  enable_o,
  output logic [CW-1:0] vector_o,
  output logic          irq_o
);
  logic [W-1:0]    latched_q;
  logic [W-1:0]    enable_q;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] vec_sel;
  logic [W-1:0]    vec_clr;
  logic            irq_q;

  evt_status_bits #(.W(W), .MASK(LMASK)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_pulse_i),
    .clr_wr_i   (status_wr_i),
    .clr_data_i (status_wdata_i),
    .vec_clr_i  (vec_clr),
    .q_o        (latched_q)
  );

  evt_enable_reg #(.W(W), .MASK(EMASK)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (enable_wr_i),
    .data_i (enable_wdata_i),
    .q_o    (enable_q)
  );

  assign pend = latched_q[NSRC-1:0] & enable_q[NSRC-1:0];

  evt_vector_enc #(.N(NSRC), .CODE_W(CW)) u_vec (
    .pend_i (pend),
    .code_o (vector_o),
    .sel_o  (vec_sel)
  );

  assign vec_clr  = W'(vec_sel) & {W{vector_rd_i}};
  assign status_o = latched_q | (W'(bus_busy_i) << BUSY_POS);
  assign enable_o = enable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_o & enable_q);
  end

  assign irq_o = irq_q;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_o & enable_o)) |=> irq_o); // R7
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_o & enable_o)) |=> !irq_o); // R7
  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_o == '0) == ((status_o[NSRC-1:0] & enable_o[NSRC-1:0]) == '0)); // R8
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vector_o) <= NSRC); // R8
  AST_VEC_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_o != '0) |-> (status_o[int'(vector_o) - 1] && enable_o[int'(vector_o) - 1]
      && (((status_o & enable_o) & ((W'(1) << (int'(vector_o) - 1)) - W'(1))) == '0))); // R8
  AST_VEC_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_rd_i && vector_o != '0 && !evt_pulse_i[int'(vector_o) - 1])
      |=> !status_o[int'($past(vector_o)) - 1]); // R9
endmodule

// File: tb/i2c_event_irq_bench.sv
module i2c_event_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt;
  logic        busy;
  logic        swr;
  logic [15:0] sdat;
  logic        ewr;
  logic [15:0] edat;
  logic        vrd;
  logic [15:0] status;
  logic [15:0] enable;
  logic [2:0]  vec;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_event_irq u_i2c_event_irq (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_pulse_i    (evt),
    .bus_busy_i     (busy),
    .status_wr_i    (swr),
    .status_wdata_i (sdat),
    .enable_wr_i    (ewr),
    .enable_wdata_i (edat),
    .vector_rd_i    (vrd),
    .status_o       (status),
    .enable_o       (enable),
    .vector_o       (vec),
    .irq_o          (irq)
  );

  typedef struct packed {
    logic [15:0] evt;
    logic        busy;
    logic        swr;
    logic [15:0] sdat;
    logic        ewr;
    logic [15:0] edat;
    logic        vrd;
    logic [15:0] exp_st;
    logic [15:0] exp_en;
    logic [2:0]  exp_vec;
    logic        exp_irq;
  } row_t;

  localparam int NROWS = 18;
  localparam row_t TBL [NROWS] = '{
    '{16'h0000,1'b0,1'b0,16'h0000,1'b1,16'hFFFF,1'b0, 16'h0000,16'h601F,3'd0,1'b0}, // R6 enable mask
    '{16'h0008,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0, 16'h0008,16'h601F,3'd4,1'b0}, // R2 R8
    '{16'h0012,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0, 16'h001A,16'h601F,3'd2,1'b1}, // R8 R7
    '{16'h0000,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1, 16'h0018,16'h601F,3'd4,1'b1}, // R9
    '{16'h0000,1'b0,1'b1,16'h0008,1'b0,16'h0000,1'b0, 16'h0010,16'h601F,3'd5,1'b1}, // R3
    '{16'h0F00,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0, 16'h0F10,16'h601F,3'd5,1'b1}, // R2
    '{16'h0400,1'b0,1'b1,16'h0F10,1'b0,16'h0000,1'b0, 16'h0400,16'h601F,3'd0,1'b1}, // R4 R3
    '{16'h0000,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0, 16'h1400,16'h601F,3'd0,1'b0}, // R5 R7
    '{16'h0000,1'b1,1'b1,16'h1400,1'b0,16'h0000,1'b0, 16'h1000,16'h601F,3'd0,1'b0}, // R5
    '{16'h0005,1'b0,1'b0,16'h0000,1'b1,16'h0002,1'b0, 16'h0005,16'h0002,3'd0,1'b0}, // R8 masked
    '{16'h0002,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0, 16'h0007,16'h0002,3'd2,1'b0}, // R7 R8
    '{16'h0002,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1, 16'h0007,16'h0002,3'd2,1'b1}, // R4 vec read
    '{16'h6000,1'b0,1'b0,16'h0000,1'b1,16'h601F,1'b0, 16'h6007,16'h601F,3'd1,1'b1}, // R2 R8
    '{16'h0000,1'b0,1'b1,16'h0004,1'b0,16'h0000,1'b1, 16'h6002,16'h601F,3'd2,1'b1}, // R10
    '{16'h0000,1'b0,1'b1,16'hFFFF,1'b0,16'h0000,1'b0, 16'h0000,16'h601F,3'd0,1'b1}, // R3
    '{16'h0000,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0, 16'h0000,16'h601F,3'd0,1'b0}, // R7
    '{16'h0000,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1, 16'h0000,16'h601F,3'd0,1'b0}, // R9 idle read
    '{16'h90E0,1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0, 16'h0000,16'h601F,3'd0,1'b0}  // R6 R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt = '0; swr = 1'b0; sdat = '0; ewr = 1'b0; edat = '0; vrd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    busy  = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 enable", 32'(enable), 32'h0);
    chk("R1 vector", 32'(vec), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    for (int k = 0; k < NROWS; k++) begin
      evt = TBL[k].evt; busy = TBL[k].busy; swr = TBL[k].swr; sdat = TBL[k].sdat;
      ewr = TBL[k].ewr; edat = TBL[k].edat; vrd = TBL[k].vrd;
      @(negedge clk);
      chk($sformatf("row %0d status (R2-set/R3/R4/R5/R6)", k), 32'(status), 32'(TBL[k].exp_st));
      chk($sformatf("row %0d enable R6", k), 32'(enable), 32'(TBL[k].exp_en));
      chk($sformatf("row %0d vector R8", k), 32'(vec), 32'(TBL[k].exp_vec));
      chk($sformatf("row %0d irq R7", k), 32'(irq), 32'(TBL[k].exp_irq));
      idle_inputs();
    end
    busy = 1'b0;

    // R8 R9: all five vector sources pending, drained by successive reads
    evt = 16'h001F;
    @(negedge clk);
    idle_inputs();
    chk("R8 top priority", 32'(vec), 32'd1);
    for (int c = 2; c <= 6; c++) begin
      vrd = 1'b1;
      @(negedge clk);
      vrd = 1'b0;
      chk("R9 drain order", 32'(vec), 32'(c % 6));
    end
    chk("R9 drained status", 32'(status), 32'h0);

    // R1: reset in the middle of activity
    evt = 16'h6F1F;
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 status after reset", 32'(status), 32'h0);
    chk("R1 enable after reset", 32'(enable), 32'h0);
    chk("R1 vector after reset", 32'(vec), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule